// File: doc/BRIEF.md
# Sample Output Formatter with Channel Tagging

This block sits between a single analogue-to-digital converter, which is shared by three colour channels, and a 12-bit tri-state pad bus. Each conversion result is presented on the bus in one of two formats. In word format, all twelve lanes carry the result for one cycle. In byte format, the result is split into two consecutive beats on the upper eight lanes, so data leaves at twice the conversion rate.

The upper eight lanes are also shared with a parallel control input. Whenever that input path owns them, the block releases those lanes and passes their pad value to the control side. A single active-low enable pin can release the whole bus.

Every result carries a colour tag taken from a sample-sync pulse. In pixel mode, each pulse steps the colour from red to green to blue and then back to red. In line mode, the colour is a fixed value that arrives as an input. The pad ring outside the block turns the data and per-lane enable outputs into the actual tri-state drivers.

Top module: `sample_out_fmt`

## Requirements
- R1: While `oe_n` is 1, every bit of `bus_en` is 0, whatever the other mode inputs are.
- R2: In word format (`byte_mode`=0, `oe_n`=0, lanes not claimed by the control input), all 12 lanes are enabled. A result accepted at a clock edge appears on `bus_o` after that edge, with its MSB on bit 11 and its LSB on bit 0, and `beat_valid` is high for exactly that one cycle.
- R3: In byte format (`byte_mode`=1), lanes 3:0 are disabled and lanes 11:4 are enabled. Two beats follow an accepted result on consecutive cycles. The first beat has result bits 11:4 on bus bits 11:4. The second beat has result bits 3:0 on bus bits 11:8 and zeros on bus bits 7:0. `beat_valid` is high for both beats, and the lower lanes of `bus_o` hold 0 in both.
- R4: In byte format, a result presented in the cycle when the second beat is still pending is ignored. The second beat of the earlier result goes out unchanged.
- R5: When `par_mode`=1 and `dir_out`=0, lanes 11:4 are disabled and `ctl_byte` equals `bus_hi_i`. In every other case, `ctl_byte` is 0 and lanes 11:4 follow R1 to R3.
- R6: In pixel mode (`line_mode`=0), each sync pulse tags the current colour and then advances it. The codes are R=0, G=1, B=2, and the order wraps from B back to R. The colour after reset is R.
- R7: In line mode (`line_mode`=1), a sync pulse tags the colour given by `line_chan`, with code 3 taken as 2, and leaves the pixel-mode position unchanged.
- R8: A result carries the tag captured by the latest sync pulse at an earlier clock edge. A pulse in the same cycle as the result only affects later results. The tag stays on `chan_tag` through both beats.
- R9: After reset, `bus_o` is 0, `beat_valid` is 0 and `chan_tag` is 0.
- R10: When no beat is being sent, `beat_valid` is 0 and `bus_o` holds the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_pulse | input | 1 | One-cycle sample-sync pulse |
| line_mode | input | 1 | 1 = line-by-line colour, 0 = pixel rotation |
| line_chan | input | 2 | Colour code used in line mode |
| res_valid | input | 1 | Conversion result present this cycle |
| res_data | input | DW | Conversion result |
| byte_mode | input | 1 | 1 = two byte beats, 0 = full word |
| par_mode | input | 1 | Control is on the parallel path |
| dir_out | input | 1 | Parallel direction, 1 = upper lanes output |
| oe_n | input | 1 | Active-low bus output enable |
| bus_hi_i | input | BW | Pad value of the upper lanes |
| bus_o | output | DW | Bus data to pads |
| bus_en | output | DW | Per-lane pad drive enable |
| ctl_byte | output | BW | Upper lane value given to the control input |
| beat_valid | output | 1 | One pulse per beat |
| chan_tag | output | 2 | Colour tag of the current beat |

## Verification
The bench builds the block with its defaults, DW=12 and BW=8. With these widths, every one of the 4096 result codes can be driven through both the word format and the byte format, so every bit of the split and every nibble placement is covered. The lane enables are checked for all combinations of the enable, parallel-mode, direction and format inputs. The 256 upper-lane pad codes are swept through the control path. The colour sequencer is driven through several full rotations, through all four line codes, and through a sync pulse that coincides with a result.

// File: rtl/sof_pkg.sv
package sof_pkg;

  typedef enum logic [1:0] {
    CH_R = 2'd0,
    CH_G = 2'd1,
    CH_B = 2'd2
  } chan_e;

  function automatic chan_e chan_step(input chan_e c);
    chan_e n;
    case (c)
      CH_R:    n = CH_G;
      CH_G:    n = CH_B;
      default: n = CH_R;
    endcase
    return n;
  endfunction

  function automatic chan_e chan_from_code(input logic [1:0] v);
    chan_e n;
    case (v)
      2'd0:    n = CH_R;
      2'd1:    n = CH_G;
      default: n = CH_B;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sof_chan_seq.sv
module sof_chan_seq
  import sof_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_pulse,
  input  logic       line_mode,
  input  logic [1:0] line_chan,
  output chan_e      samp_tag,
  output chan_e      ptr
);

  chan_e ptr_q, ptr_d;
  chan_e tag_q, tag_d;

  always_comb begin
    ptr_d = ptr_q;
    tag_d = tag_q;
    if (line_mode) begin
      tag_d = chan_from_code(line_chan);
    end else begin
      tag_d = ptr_q;
      ptr_d = chan_step(ptr_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= CH_R;
      tag_q <= CH_R;
    end else if (sync_pulse) begin
      ptr_q <= ptr_d;
      tag_q <= tag_d;
    end
  end

  assign samp_tag = tag_q;
  assign ptr      = ptr_q;

endmodule

// File: rtl/sof_beat_fmt.sv
module sof_beat_fmt
  import sof_pkg::*;
#(
  parameter int DW = 12,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data,
  input  logic          byte_mode,
  input  chan_e         in_tag,
  output logic [DW-1:0] out_word,
  output logic          out_valid,
  output chan_e         out_tag
);

  localparam int LO_W  = DW - BW;
  localparam int PAD_W = 2 * BW - DW;

  logic [DW-1:0]   word_q, word_d;
  logic            valid_q, valid_d;
  logic            pend_q, pend_d;
  logic [LO_W-1:0] lo_q, lo_d;
  chan_e           tag_q, tag_d;
  logic            take;

  assign take = res_valid && !pend_q;

  always_comb begin
    word_d  = word_q;
    valid_d = 1'b0;
    pend_d  = 1'b0;
    lo_d    = lo_q;
    tag_d   = tag_q;
    if (pend_q) begin
      word_d  = {lo_q, {PAD_W{1'b0}}, {LO_W{1'b0}}};
      valid_d = 1'b1;
    end else if (take) begin
      valid_d = 1'b1;
      tag_d   = in_tag;
      lo_d    = res_data[LO_W-1:0];
      if (byte_mode) begin
        word_d = {res_data[DW-1:LO_W], {LO_W{1'b0}}};
        pend_d = 1'b1;
      end else begin
        word_d = res_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
      lo_q    <= '0;
      tag_q   <= CH_R;
    end else begin
      word_q  <= word_d;
      valid_q <= valid_d;
      pend_q  <= pend_d;
      lo_q    <= lo_d;
      tag_q   <= tag_d;
    end
  end

  assign out_word  = word_q;
  assign out_valid = valid_q;
  assign out_tag   = tag_q;

endmodule

// File: rtl/sof_lane_ctl.sv
module sof_lane_ctl #(
  parameter int DW = 12,
  parameter int BW = 8
) (
  input  logic          oe_n,
  input  logic          par_mode,
  input  logic          dir_out,
  input  logic          byte_mode,
  input  logic [BW-1:0] bus_hi_i,
  output logic [DW-1:0] bus_en,
  output logic [BW-1:0] ctl_byte
);

  localparam int LO_W = DW - BW;

  logic ctl_owns;
  logic hi_en;
  logic lo_en;

  assign ctl_owns = par_mode && !dir_out;
  assign hi_en    = !oe_n && !ctl_owns;
  assign lo_en    = !oe_n && !byte_mode;
  assign ctl_byte = ctl_owns ? bus_hi_i : '0;

  for (genvar i = 0; i < DW; i++) begin : g_lane
    if (i >= LO_W) begin : g_hi
      assign bus_en[i] = hi_en;
    end else begin : g_lo
      assign bus_en[i] = lo_en;
    end
  end

endmodule

// File: rtl/sample_out_fmt.sv
module sample_out_fmt
  import sof_pkg::*;
#(
  parameter int DW = 12,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_pulse,
  input  logic          line_mode,
  input  logic [1:0]    line_chan,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data,
  input  logic          byte_mode,
  input  logic          par_mode,
  input  logic          dir_out,
  input  logic          oe_n,
  input  logic [BW-1:0] bus_hi_i,
  output logic [DW-1:0] bus_o,
  output logic [DW-1:0] bus_en,
  output logic [BW-1:0] ctl_byte,
  output logic          beat_valid,
  output logic [1:0]    chan_tag
);

  chan_e samp_tag;
  chan_e seq_ptr;
  chan_e beat_tag;

  sof_chan_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_pulse (sync_pulse),
    .line_mode  (line_mode),
    .line_chan  (line_chan),
    .samp_tag   (samp_tag),
    .ptr        (seq_ptr)
  );

  sof_beat_fmt #(.DW(DW), .BW(BW)) u_beat (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .res_data  (res_data),
    .byte_mode (byte_mode),
    .in_tag    (samp_tag),
    .out_word  (bus_o),
    .out_valid (beat_valid),
    .out_tag   (beat_tag)
  );

  sof_lane_ctl #(.DW(DW), .BW(BW)) u_lane (
    .oe_n      (oe_n),
    .par_mode  (par_mode),
    .dir_out   (dir_out),
    .byte_mode (byte_mode),
    .bus_hi_i  (bus_hi_i),
    .bus_en    (bus_en),
    .ctl_byte  (ctl_byte)
  );

  assign chan_tag = beat_tag;

endmodule

// File: rtl/sof_out_fmt_chk.sv
module sof_out_fmt_chk #(
  parameter int DW = 12,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          res_valid,
  input logic          sync_pulse,
  input logic          line_mode,
  input logic          par_mode,
  input logic          dir_out,
  input logic          oe_n,
  input logic [DW-1:0] bus_en,
  input logic [DW-1:0] bus_o,
  input logic          beat_valid,
  input logic [1:0]    chan_tag,
  input logic [1:0]    seq_ptr
);

  a_r1_oe_releases_all: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (bus_en == '0));

  a_r5_upper_released: assert property (@(posedge clk) disable iff (!rst_n)
    (par_mode && !dir_out) |-> (bus_en[DW-1:DW-BW] == '0));

  a_r10_beat_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> ($past(res_valid) || $past(beat_valid)));

  a_r3_tail_beat_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !$past(res_valid)) |-> (bus_o[BW-1:0] == '0));

  a_r6_pixel_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse && !line_mode) |=>
      (seq_ptr == (($past(seq_ptr) == 2'd2) ? 2'd0 : ($past(seq_ptr) + 2'd1))));

  a_r7_line_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse && line_mode) |=> $stable(seq_ptr));

  a_r8_tag_legal: assert property (@(posedge clk) disable iff (!rst_n)
    chan_tag != 2'd3);

endmodule

bind sample_out_fmt sof_out_fmt_chk #(.DW(DW), .BW(BW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .res_valid  (res_valid),
  .sync_pulse (sync_pulse),
  .line_mode  (line_mode),
  .par_mode   (par_mode),
  .dir_out    (dir_out),
  .oe_n       (oe_n),
  .bus_en     (bus_en),
  .bus_o      (bus_o),
  .beat_valid (beat_valid),
  .chan_tag   (chan_tag),
  .seq_ptr    (seq_ptr)
);

// File: tb/sample_out_fmt_tb.sv
module sample_out_fmt_tb;

  localparam int DW = 12;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sync_pulse;
  logic          line_mode;
  logic [1:0]    line_chan;
  logic          res_valid;
  logic [DW-1:0] res_data;
  logic          byte_mode;
  logic          par_mode;
  logic          dir_out;
  logic          oe_n;
  logic [BW-1:0] bus_hi_i;
  logic [DW-1:0] bus_o;
  logic [DW-1:0] bus_en;
  logic [BW-1:0] ctl_byte;
  logic          beat_valid;
  logic [1:0]    chan_tag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int exp_ptr = 0;
  int exp_tag = 0;

  always #10 clk = ~clk;

  sample_out_fmt #(.DW(DW), .BW(BW)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_pulse (sync_pulse),
    .line_mode  (line_mode),
    .line_chan  (line_chan),
    .res_valid  (res_valid),
    .res_data   (res_data),
    .byte_mode  (byte_mode),
    .par_mode   (par_mode),
    .dir_out    (dir_out),
    .oe_n       (oe_n),
    .bus_hi_i   (bus_hi_i),
    .bus_o      (bus_o),
    .bus_en     (bus_en),
    .ctl_byte   (ctl_byte),
    .beat_valid (beat_valid),
    .chan_tag   (chan_tag)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // one-cycle sync pulse; bench model of the colour sequencer
  task automatic pulse_sync();
    @(negedge clk);
    sync_pulse = 1'b1;
    @(negedge clk);
    sync_pulse = 1'b0;
    if (line_mode) begin
      exp_tag = (line_chan > 2'd2) ? 2 : int'(line_chan);
    end else begin
      exp_tag = exp_ptr;
      exp_ptr = (exp_ptr + 1) % 3;
    end
  endtask

  // word-format result: one beat, then idle with held data
  task automatic send_word(input int v, input string rq);
    @(negedge clk);
    res_valid = 1'b1;
    res_data  = DW'(v);
    @(negedge clk);
    res_valid = 1'b0;
    chk(bus_o == DW'(v), rq, int'(bus_o), v);
    chk(beat_valid == 1'b1, rq, int'(beat_valid), 1);
    chk(chan_tag == 2'(exp_tag), "R8", int'(chan_tag), exp_tag);
    @(negedge clk);
    chk(beat_valid == 1'b0 && bus_o == DW'(v), "R10", int'(bus_o), v);
  endtask

  // byte-format result: two beats on upper lanes
  task automatic send_byte(input int v, input string rq);
    int e0;
    int e1;
    e0 = (v >> 4) << 4;
    e1 = (v & 15) << 8;
    @(negedge clk);
    res_valid = 1'b1;
    res_data  = DW'(v);
    @(negedge clk);
    res_valid = 1'b0;
    chk(bus_o == DW'(e0) && beat_valid, rq, int'(bus_o), e0);
    chk(chan_tag == 2'(exp_tag), "R8", int'(chan_tag), exp_tag);
    @(negedge clk);
    chk(bus_o == DW'(e1) && beat_valid, rq, int'(bus_o), e1);
    chk(chan_tag == 2'(exp_tag), "R8", int'(chan_tag), exp_tag);
    @(negedge clk);
    chk(beat_valid == 1'b0, "R10", int'(beat_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sync_pulse = 1'b0; line_mode = 1'b0; line_chan = 2'd0;
    res_valid = 1'b0; res_data = '0; byte_mode = 1'b0; par_mode = 1'b0;
    dir_out = 1'b1; oe_n = 1'b0; bus_hi_i = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(bus_o == '0, "R9", int'(bus_o), 0);
    chk(beat_valid == 1'b0, "R9", int'(beat_valid), 0);
    chk(chan_tag == 2'd0, "R9", int'(chan_tag), 0);
    rst_n = 1'b1;

    // R1 and R5: lane enables over every mode combination
    for (int m = 0; m < 16; m++) begin
      int exp_en;
      oe_n = m[0]; par_mode = m[1]; dir_out = m[2]; byte_mode = m[3];
      #1;
      if (oe_n) exp_en = 0;
      else exp_en = ((par_mode && !dir_out) ? 0 : 12'hFF0) | (byte_mode ? 0 : 12'h00F);
      chk(bus_en == DW'(exp_en), oe_n ? "R1" : "R5", int'(bus_en), exp_en);
    end

    // R5: control path sees upper lanes only when it owns them
    oe_n = 1'b0; byte_mode = 1'b0;
    for (int b = 0; b < 256; b++) begin
      bus_hi_i = BW'(b);
      par_mode = 1'b1; dir_out = 1'b0;
      #1;
      chk(ctl_byte == BW'(b), "R5", int'(ctl_byte), b);
      dir_out = 1'b1;
      #1;
      chk(ctl_byte == '0, "R5", int'(ctl_byte), 0);
    end
    par_mode = 1'b0; dir_out = 1'b1;

    // R2: every code in word format
    byte_mode = 1'b0;
    for (int v = 0; v < 4096; v++) send_word(v, "R2");
    chk(bus_en == 12'hFFF, "R2", int'(bus_en), 12'hFFF);

    // R3: every code in byte format
    byte_mode = 1'b1;
    for (int v = 0; v < 4096; v++) send_byte(v, "R3");
    chk(bus_en == 12'hFF0, "R3", int'(bus_en), 12'hFF0);

    // R4: result during pending second beat is dropped
    @(negedge clk);
    res_valid = 1'b1; res_data = 12'hA5C;
    @(negedge clk);
    res_data = 12'h3E7;
    chk(bus_o == 12'hA50, "R4", int'(bus_o), 12'hA50);
    @(negedge clk);
    res_valid = 1'b0;
    chk(bus_o == 12'hC00 && beat_valid, "R4", int'(bus_o), 12'hC00);
    @(negedge clk);
    chk(beat_valid == 1'b0 && bus_o == 12'hC00, "R4", int'(bus_o), 12'hC00);
    send_byte(12'h3E7, "R4");

    // R6: pixel rotation over several wraps
    line_mode = 1'b0;
    for (int k = 0; k < 9; k++) begin
      pulse_sync();
      chk(exp_tag == k % 3, "R6", exp_tag, k % 3);
      byte_mode = k[0];
      if (k[0]) send_byte(k * 291, "R6");
      else send_word(k * 291, "R6");
    end

    // R7: line mode codes, 3 taken as 2, pointer held
    line_mode = 1'b1;
    for (int c = 0; c < 4; c++) begin
      line_chan = 2'(c);
      pulse_sync();
      send_word(c + 100, "R7");
    end
    line_mode = 1'b0;
    pulse_sync();
    chk(exp_tag == 0, "R7", exp_tag, 0);
    send_word(12'h777, "R7");

    // R8: sync coincident with result applies to later results only
    byte_mode = 1'b0;
    @(negedge clk);
    sync_pulse = 1'b1; res_valid = 1'b1; res_data = 12'h123;
    @(negedge clk);
    sync_pulse = 1'b0; res_valid = 1'b0;
    chk(chan_tag == 2'(exp_tag), "R8", int'(chan_tag), exp_tag);
    exp_tag = exp_ptr;
    exp_ptr = (exp_ptr + 1) % 3;
    send_word(12'h456, "R8");

    finish_run();
  end

endmodule